// File: doc/BRIEF.md
# Hierarchical AND/OR Barrier Tree

This block joins many leaf endpoints into one synchronisation fabric. Every leaf drives one level per channel. A tree of combining nodes reduces those levels on the way up, and the result at the top of each partition is sent back down to every leaf below it. Each channel gives two results at every leaf. The any-set result is the OR of the partition's levels and serves as a global alert or halt line. The all-set result is the AND of the same levels and serves as the barrier. The AND is formed with the same OR gate, fed inverted levels, with its result inverted again.

Leaves use a two-phase protocol. A leaf arrives at a barrier by raising its level. The all-set output goes high once every leaf in the partition has risen. The next barrier uses the opposite edge: the leaves drop their levels, and the any-set output falls once the last leaf has dropped. Each tree level adds one register on the way up and one on the way down. A set of cut bits, one per internal level, can make every node of that level the root of its own partition.

Top module: `barrier_tree`

## Requirements
- R1: While rst_n is low, every bit of glob_or and glob_and reads 0, whatever leaf_lvl holds.
- R2: Bit c of glob_or at leaf j equals the OR of bit c of leaf_lvl over all leaves in the partition of leaf j. The packed index of bit c at leaf j is j*CH+c.
- R3: Bit c of glob_and at leaf j equals the AND of the same set of leaf bits.
- R4: Channels are independent. A change on one channel's inputs never alters another channel's outputs.
- R5: With cut_lvl all zero, all FANIN**DEPTH leaves form one partition. A change applied before rising edge 1 appears at the outputs after rising edge 2*DEPTH and not after edge 2*DEPTH-1.
- R6: Bit l-1 of cut_lvl makes every node at level l a root, where level 1 is the row just above the leaves. Its partition is the FANIN**l consecutive leaves that share the value of index / FANIN**l. The lowest set bit decides the partition. Latency then drops to 2*l edges.
- R7: While any leaf in a partition holds a channel low, no leaf of that partition sees glob_and high on that channel. Leaves in other partitions are unaffected.
- R8: glob_and is never high at a bit where glob_or is low.
- R9: Once leaf_lvl and cut_lvl have been steady for 2*DEPTH rising edges, both outputs stay steady.
- R10: For a falling phase, glob_or stays high until the last leaf of the partition has dropped. It then falls after the same latency as in R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| leaf_lvl | input | FANIN**DEPTH x CH | Level driven by each leaf on each channel |
| cut_lvl | input | DEPTH-1 | Partition cut bit per internal level, bit 0 for level 1 |
| glob_or | output | FANIN**DEPTH x CH | Per-leaf, per-channel OR of the partition |
| glob_and | output | FANIN**DEPTH x CH | Per-leaf, per-channel AND of the partition |

## Verification
A result is due 2*k rising edges after its stimulus, where k is the level of the partition root: DEPTH with no cut, or the lowest cut level. The bench changes inputs on falling edges and counts falling edges after the change. For the latency checks it samples once one edge before the due edge, to see the old value, and once at the due edge, to see the new one. The table-driven checks wait 2*DEPTH+1 edges, so every cut setting has settled. The bound checker only compares outputs with the partition reductions after a counter has seen 2*DEPTH steady edges, which keeps each comparison inside the window where the result is due.

// File: rtl/barrier_tree_pkg.sv
package barrier_tree_pkg;
   // integer power, used for node counts per level and partition sizes
   function automatic int ipow(input int base, input int expo);
      int acc;
      acc = 1;
      for (int i = 0; i < expo; i++) acc = acc * base;
      return acc;
   endfunction
endpackage

// File: rtl/barrier_up_node.sv
// Upward combining node: OR of children on the any-path, OR of inverted
// children on the miss-path (AND obtained by inverting the miss result).
module barrier_up_node #(
   parameter int FANIN = 2,
   parameter int CH    = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [FANIN-1:0][CH-1:0]  kid_any,
   input  logic [FANIN-1:0][CH-1:0]  kid_miss,
   output logic [CH-1:0]             up_any,
   output logic [CH-1:0]             up_miss
);
   logic [CH-1:0] any_c;
   logic [CH-1:0] miss_c;

   always_comb begin
      any_c  = '0;
      miss_c = '0;
      for (int k = 0; k < FANIN; k++) begin
         any_c  = any_c  | kid_any[k];
         miss_c = miss_c | kid_miss[k];
      end
   end

   // reset state equals the steady state of all-low leaves
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_any  <= '0;
         up_miss <= '1;
      end else begin
         up_any  <= any_c;
         up_miss <= miss_c;
      end
   end
endmodule

// File: rtl/barrier_dn_node.sv
// Downward broadcast stage: a root reflects its own reduction, any other
// node forwards its parent's broadcast value.
module barrier_dn_node #(
   parameter int CH = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           is_root,
   input  logic [CH-1:0]  own_any,
   input  logic [CH-1:0]  own_miss,
   input  logic [CH-1:0]  par_any,
   input  logic [CH-1:0]  par_miss,
   output logic [CH-1:0]  dn_any,
   output logic [CH-1:0]  dn_miss
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dn_any  <= '0;
         dn_miss <= '1;
      end else if (is_root) begin
         dn_any  <= own_any;
         dn_miss <= own_miss;
      end else begin
         dn_any  <= par_any;
         dn_miss <= par_miss;
      end
   end
endmodule

// File: rtl/barrier_tree.sv
module barrier_tree
   import barrier_tree_pkg::*;
#(
   parameter int FANIN = 2,
   parameter int DEPTH = 3,
   parameter int CH    = 4,
   localparam int NUM_LEAVES = ipow(FANIN, DEPTH)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_LEAVES-1:0][CH-1:0]   leaf_lvl,
   input  logic [DEPTH-2:0]                cut_lvl,
   output logic [NUM_LEAVES-1:0][CH-1:0]   glob_or,
   output logic [NUM_LEAVES-1:0][CH-1:0]   glob_and
);
   // elaboration-time parameter checks
   if (FANIN < 2) begin : g_bad_fanin
      $error("barrier_tree: FANIN must be at least 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("barrier_tree: DEPTH must be at least 2");
   end
   if (CH < 1) begin : g_bad_ch
      $error("barrier_tree: CH must be at least 1");
   end
   if (NUM_LEAVES > 4096) begin : g_bad_size
      $error("barrier_tree: leaf count too large");
   end

   // up-sweep: level l holds FANIN**(DEPTH-l) nodes, one register stage each
   for (genvar l = 1; l <= DEPTH; l++) begin : g_up
      localparam int NODES = ipow(FANIN, DEPTH - l);
      logic [NODES-1:0][CH-1:0] any_q;
      logic [NODES-1:0][CH-1:0] miss_q;
      for (genvar n = 0; n < NODES; n++) begin : g_node
         logic [FANIN-1:0][CH-1:0] k_any;
         logic [FANIN-1:0][CH-1:0] k_miss;
         for (genvar k = 0; k < FANIN; k++) begin : g_kid
            if (l == 1) begin : g_leaf
               assign k_any[k]  = leaf_lvl[n*FANIN + k];
               assign k_miss[k] = ~leaf_lvl[n*FANIN + k];
            end else begin : g_inner
               assign k_any[k]  = g_up[l-1].any_q[n*FANIN + k];
               assign k_miss[k] = g_up[l-1].miss_q[n*FANIN + k];
            end
         end
         barrier_up_node #(.FANIN(FANIN), .CH(CH)) u_up (
            .clk      (clk),
            .rst_n    (rst_n),
            .kid_any  (k_any),
            .kid_miss (k_miss),
            .up_any   (any_q[n]),
            .up_miss  (miss_q[n])
         );
      end
   end

   // down-sweep, built from the top level downward
   for (genvar l = DEPTH; l >= 1; l--) begin : g_dn
      localparam int NODES = ipow(FANIN, DEPTH - l);
      logic [NODES-1:0][CH-1:0] any_q;
      logic [NODES-1:0][CH-1:0] miss_q;
      for (genvar n = 0; n < NODES; n++) begin : g_node
         logic          root;
         logic [CH-1:0] p_any;
         logic [CH-1:0] p_miss;
         if (l == DEPTH) begin : g_top
            assign root   = 1'b1;
            assign p_any  = g_up[l].any_q[n];
            assign p_miss = g_up[l].miss_q[n];
         end else begin : g_mid
            assign root   = cut_lvl[l-1];
            assign p_any  = g_dn[l+1].any_q[n / FANIN];
            assign p_miss = g_dn[l+1].miss_q[n / FANIN];
         end
         barrier_dn_node #(.CH(CH)) u_dn (
            .clk      (clk),
            .rst_n    (rst_n),
            .is_root  (root),
            .own_any  (g_up[l].any_q[n]),
            .own_miss (g_up[l].miss_q[n]),
            .par_any  (p_any),
            .par_miss (p_miss),
            .dn_any   (any_q[n]),
            .dn_miss  (miss_q[n])
         );
      end
   end

   // leaf outputs: AND restored by inverting the miss-path result
   for (genvar j = 0; j < NUM_LEAVES; j++) begin : g_leaf_out
      assign glob_or[j]  = g_dn[1].any_q[j / FANIN];
      assign glob_and[j] = ~g_dn[1].miss_q[j / FANIN];
   end
endmodule

// File: rtl/barrier_tree_chk.sv
module barrier_tree_chk
   import barrier_tree_pkg::*;
#(
   parameter int FANIN = 2,
   parameter int DEPTH = 3,
   parameter int CH    = 4,
   localparam int NUM_LEAVES = ipow(FANIN, DEPTH)
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic [NUM_LEAVES-1:0][CH-1:0]  leaf_lvl,
   input logic [DEPTH-2:0]               cut_lvl,
   input logic [NUM_LEAVES-1:0][CH-1:0]  glob_or,
   input logic [NUM_LEAVES-1:0][CH-1:0]  glob_and
);
   localparam int LIM = 2 * DEPTH;
   localparam int QW  = $clog2(LIM + 1);

   logic [NUM_LEAVES-1:0][CH-1:0] last_leaf;
   logic [DEPTH-2:0]              last_cut;
   logic [QW-1:0]                 quiet;
   logic                          same_now;
   logic [NUM_LEAVES-1:0][CH-1:0] exp_or;
   logic [NUM_LEAVES-1:0][CH-1:0] exp_and;

   assign same_now = (leaf_lvl == last_leaf) && (cut_lvl == last_cut);

   // counts consecutive edges with unchanged inputs, saturating at LIM
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_leaf <= '0;
         last_cut  <= '0;
         quiet     <= '0;
      end else begin
         last_leaf <= leaf_lvl;
         last_cut  <= cut_lvl;
         if (!same_now) quiet <= '0;
         else if (quiet < QW'(LIM)) quiet <= quiet + 1'b1;
      end
   end

   // partition reductions taken straight from the requirements
   always_comb begin
      int root_lvl;
      int grp;
      root_lvl = DEPTH;
      for (int l = DEPTH - 1; l >= 1; l--) if (cut_lvl[l-1]) root_lvl = l;
      grp = ipow(FANIN, root_lvl);
      exp_or  = '0;
      exp_and = '1;
      for (int j = 0; j < NUM_LEAVES; j++)
         for (int i = 0; i < NUM_LEAVES; i++)
            if ((i / grp) == (j / grp)) begin
               exp_or[j]  = exp_or[j]  | leaf_lvl[i];
               exp_and[j] = exp_and[j] & leaf_lvl[i];
            end
   end

   assert_or_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet == QW'(LIM) && same_now) |-> (glob_or == exp_or));

   assert_and_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet == QW'(LIM) && same_now) |-> (glob_and == exp_and));

   assert_and_implies_or_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((glob_and & ~glob_or) == '0));

   assert_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet == QW'(LIM) && same_now) |-> ($stable(glob_or) && $stable(glob_and)));
endmodule

bind barrier_tree barrier_tree_chk #(.FANIN(FANIN), .DEPTH(DEPTH), .CH(CH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .leaf_lvl (leaf_lvl),
   .cut_lvl  (cut_lvl),
   .glob_or  (glob_or),
   .glob_and (glob_and)
);

// File: tb/barrier_tree_bench.sv
module barrier_tree_bench;
   localparam int FANIN  = 2;
   localparam int DEPTH  = 3;
   localparam int CH     = 4;
   localparam int W      = 32;          // 8 leaves x 4 channels
   localparam int LAT    = 2 * DEPTH;
   localparam int SETTLE = 2 * DEPTH + 1;

   typedef struct packed {
      logic [1:0]   cut;
      logic [W-1:0] leaf;
      logic [W-1:0] e_or;
      logic [W-1:0] e_and;
   } vec_t;

   // bit index of channel c at leaf j is j*4+c
   localparam vec_t VECS [9] = '{
      '{2'b00, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},  // R2 R3 idle
      '{2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF},  // R3 all arrived
      '{2'b00, 32'h0000_0001, 32'h1111_1111, 32'h0000_0000},  // R2 single leaf
      '{2'b00, 32'hFFFF_FFF7, 32'hFFFF_FFFF, 32'h7777_7777},  // R7 one missing
      '{2'b01, 32'h0000_00FF, 32'h0000_00FF, 32'h0000_00FF},  // R6 pairs
      '{2'b10, 32'h0000_F000, 32'h0000_FFFF, 32'h0000_0000},  // R6 quads
      '{2'b11, 32'h0000_F000, 32'h0000_FF00, 32'h0000_0000},  // R6 lowest cut wins
      '{2'b10, 32'hFFFF_0000, 32'hFFFF_0000, 32'hFFFF_0000},  // R6 R7 upper quad
      '{2'b00, 32'h2222_2222, 32'h2222_2222, 32'h2222_2222}   // R4 one channel
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] leaf_lvl = '0;
   logic [1:0]   cut_lvl = '0;
   logic [W-1:0] glob_or;
   logic [W-1:0] glob_and;
   int           n_chk = 0;
   int           n_fail = 0;
   logic         done = 1'b0;

   always #10ns clk = ~clk;

   barrier_tree #(.FANIN(FANIN), .DEPTH(DEPTH), .CH(CH)) u_barrier_tree (
      .clk      (clk),
      .rst_n    (rst_n),
      .leaf_lvl (leaf_lvl),
      .cut_lvl  (cut_lvl),
      .glob_or  (glob_or),
      .glob_and (glob_and)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(200000 * 20ns);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] snap_or;
      logic [W-1:0] snap_and;
      // R1: outputs low in reset even with every leaf high
      leaf_lvl = '1;
      wait_neg(3);
      check("R1 or in reset", glob_or, '0);
      check("R1 and in reset", glob_and, '0);
      rst_n = 1'b1;
      // R5: full-depth latency of 2*DEPTH edges
      wait_neg(LAT - 1);
      check("R5 and before due edge", glob_and, '0);
      wait_neg(1);
      check("R5 and at due edge", glob_and, '1);
      check("R5 or at due edge", glob_or, '1);
      leaf_lvl = '0;
      wait_neg(SETTLE);

      // table walk
      for (int v = 0; v < 9; v++) begin
         cut_lvl  = VECS[v].cut;
         leaf_lvl = VECS[v].leaf;
         wait_neg(SETTLE);
         check($sformatf("R2 or vector %0d", v), glob_or, VECS[v].e_or);
         check($sformatf("R3 and vector %0d", v), glob_and, VECS[v].e_and);
      end

      // R6: level-1 cut shortens latency to 2 edges
      cut_lvl = 2'b01; leaf_lvl = '0;
      wait_neg(SETTLE);
      leaf_lvl = '1;
      wait_neg(1);
      check("R6 and before due edge", glob_and, '0);
      wait_neg(1);
      check("R6 and at due edge", glob_and, '1);

      // R7: barrier holds until the last leaf arrives
      cut_lvl = 2'b00; leaf_lvl = '0;
      wait_neg(SETTLE);
      leaf_lvl = 32'h0FFF_FFFF;
      wait_neg(SETTLE);
      check("R7 and with leaf7 low", glob_and, '0);
      check("R7 or with leaf7 low", glob_or, '1);
      leaf_lvl = '1;
      wait_neg(LAT - 1);
      check("R7 and one edge early", glob_and, '0);
      wait_neg(1);
      check("R7 and released", glob_and, '1);

      // R10: falling phase completes on the last leaf dropping
      leaf_lvl = 32'hF000_0000;
      wait_neg(SETTLE);
      check("R10 or while leaf7 high", glob_or, '1);
      check("R10 and after first drops", glob_and, '0);
      leaf_lvl = '0;
      wait_neg(LAT - 1);
      check("R10 or one edge early", glob_or, '1);
      wait_neg(1);
      check("R10 or fallen", glob_or, '0);

      // R4: dropping channel 2 of leaf 5 touches only channel 2
      leaf_lvl = '1;
      wait_neg(SETTLE);
      leaf_lvl = 32'hFFBF_FFFF;
      wait_neg(SETTLE);
      check("R4 and other channels intact", glob_and, 32'hBBBB_BBBB);
      check("R4 or unchanged", glob_or, '1);

      // R9: steady inputs keep steady outputs
      snap_or  = glob_or;
      snap_and = glob_and;
      wait_neg(3);
      check("R9 or steady", glob_or, snap_or);
      check("R9 and steady", glob_and, snap_and);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule